// File: doc/BRIEF.md
# 2D Block Copy Engine

The engine accepts a six-word rectangle-copy command from a host over a valid/ready word channel. It validates the header and the reserved fields of the command, then walks a destination rectangle one scanline at a time. For every destination byte it fetches the matching source byte and the current destination byte. It merges the two through an 8-bit raster operation code and writes the merged byte back.

The memory side is a single byte-wide port with one cycle of read latency. Each surface has its own signed row pitch, and one horizontal-direction bit steers both the source and the destination address streams. Software can therefore pick the walk order that keeps an overlapping copy correct, including a copy whose source and destination share a 32-byte line.

A rejected command raises a sticky error flag, and no memory is written. An empty rectangle finishes at once.

Top module: `blit_copy_engine`

## Requirements
- R1: Word 0 must equal client 3'd2 in bits 31:29, opcode 7'h43 in bits 28:22, zero in bits 21:5 and length 5'd4 in bits 4:0. Any other value rejects the command: err_o is set, done_o pulses and no memory write occurs.
- R2: In word 1, bit 31 and bits 29:27 must be 0 and bit 26 must be 1. The depth field, bits 25:24, may hold 00, 01 or 10. The value 11, or any other violation of these bits, rejects the command as in R1.
- R3: Word 4 holds the source pitch in bits 13:0. Bits 31:14 must be zero and bits 2:0 must be zero, because the pitch is a multiple of eight. Otherwise the command is rejected as in R1.
- R4: Word 1 bit 30 sets the direction. When it is 0, both addresses increment along a row. When it is 1, both addresses decrement along a row, starting from the given start addresses, which then name the rightmost bytes.
- R5: After each scanline, the signed destination pitch (word 1 bits 15:0) is added to the destination row start. The signed source pitch (word 4 bits 13:0) is added to the source row start. Negative pitches walk upward.
- R6: Word 2 gives the width in bytes (bits 15:0) and the height in rows (bits 31:16). Word 3 is the first destination byte and word 5 is the first source byte. Exactly width*height bytes are written.
- R7: Result bit i is rop[{1'b0, src[i], dst[i]}]. With this rule, 8'hCC copies the source, 8'h66 gives XOR, 8'h88 gives AND and 8'h11 gives NOR.
- R8: For each byte, both reads finish before that byte is written. A walk order chosen for the overlap therefore yields move semantics, even when source and destination share one aligned 32-byte line.
- R9: A legal command with a width or height of zero pulses done_o with no memory write and no error.
- R10: busy_o rises on acceptance of word 0 and stays high until done_o pulses for one cycle after the last write. cmd_ready_o is low while the engine is executing.
- R11: err_o stays set until reset, including through later legal commands, which still execute. A command that is both illegal and empty is reported as an error.
- R12: After reset, cmd_ready_o is 1 and busy_o, done_o, err_o and mem_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Engine can take a command word |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the address |
| busy_o | output | 1 | Command in collection or execution |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky command rejection flag |

## Verification
Two decisions fall in the same decision cycle: rejecting a malformed header and short-circuiting an empty rectangle. Error must win. The bench provokes this with a command that carries a bad opcode and a zero width. It judges the outcome by a set err_o, a done_o pulse and zero write cycles. A second coincidence arises on the last byte of a scanline, where the column wrap and the pitch addition happen on the same step. Vectors that use negative pitches and backward rows compare the whole memory image with an independent model after every command.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NUM_DW = 6;
  localparam int DIM_W  = 16;
  localparam int DP_W   = 16;
  localparam int SP_W   = 14;
  localparam logic [2:0] CLIENT_2D  = 3'd2;
  localparam logic [6:0] OPC_COPY   = 7'h43;
  localparam logic [4:0] LEN_FIELD  = 5'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD_SRC, ST_RD_DST, ST_WRITE
  } eng_state_e;

  typedef struct packed {
    logic              back;
    logic [7:0]        rop;
    logic [DP_W-1:0]   dpitch;
    logic [SP_W-1:0]   spitch;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [31:0]       dst;
    logic [31:0]       src;
  } blit_cmd_t;
endpackage

// File: rtl/blit_rop.sv
module blit_rop #(
  parameter int DATA_W = 8
) (
  input  logic [7:0]        rop_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign res_o[b] = rop_i[{1'b0, src_i[b], dst_i[b]}];
  end
endmodule

// File: rtl/blit_cmd_decode.sv
module blit_cmd_decode
  import blit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid_i,
  input  logic [31:0] in_data_i,
  input  logic      in_ready_i,
  output logic      last_word_o,
  output logic      collecting_o,
  output blit_cmd_t cmd_o,
  output logic      legal_o
);
  localparam int IDX_W = $clog2(NUM_DW);

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      word_q [NUM_DW];
  logic             accept;

  assign accept       = in_valid_i && in_ready_i;
  assign last_word_o  = accept && (idx_q == IDX_W'(NUM_DW - 1));
  assign collecting_o = (idx_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (accept) begin
      if (idx_q == IDX_W'(NUM_DW - 1)) idx_q <= '0;
      else                             idx_q <= idx_q + IDX_W'(1);
    end
  end

  // Storage without reset so it maps onto plain registers or distributed RAM.
  always_ff @(posedge clk) begin
    if (accept) word_q[idx_q] <= in_data_i;
  end

  assign cmd_o.back   = word_q[1][30];
  assign cmd_o.rop    = word_q[1][23:16];
  assign cmd_o.dpitch = word_q[1][DP_W-1:0];
  assign cmd_o.spitch = word_q[4][SP_W-1:0];
  assign cmd_o.width  = word_q[2][DIM_W-1:0];
  assign cmd_o.height = word_q[2][31:16];
  assign cmd_o.dst    = word_q[3];
  assign cmd_o.src    = word_q[5];

  logic hdr_ok, ctl_ok, sp_ok;
  assign hdr_ok = (word_q[0] == {CLIENT_2D, OPC_COPY, 17'd0, LEN_FIELD});
  assign ctl_ok = !word_q[1][31] && (word_q[1][29:27] == 3'b000) &&
                  word_q[1][26] && (word_q[1][25:24] != 2'b11);
  assign sp_ok  = (word_q[4][31:14] == '0) && (word_q[4][2:0] == 3'b000);
  assign legal_o = hdr_ok && ctl_ok && sp_ok;

  // R10: while a command is partly collected the engine keeps accepting words
  assert_ready_while_collecting_R10: assert property (@(posedge clk) disable iff (rst)
    collecting_o |-> in_ready_i);
endmodule

// File: rtl/blit_addr_walker.sv
module blit_addr_walker
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              back_i,
  input  logic [ADDR_W-1:0] dst0_i,
  input  logic [ADDR_W-1:0] src0_i,
  input  logic [DP_W-1:0]   dpitch_i,
  input  logic [SP_W-1:0]   spitch_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] row_dst_q, row_src_q, dp_ext, sp_ext;
  logic [ADDR_W-1:0] nxt_row_dst, nxt_row_src;
  logic [DIM_W-1:0]  col_q, row_q;
  logic              col_end, row_end;

  assign dp_ext      = ADDR_W'(signed'(dpitch_i));
  assign sp_ext      = ADDR_W'(signed'(spitch_i));
  assign nxt_row_dst = row_dst_q + dp_ext;
  assign nxt_row_src = row_src_q + sp_ext;
  assign col_end     = (col_q == width_i - DIM_W'(1));
  assign row_end     = (row_q == height_i - DIM_W'(1));
  assign last_o      = col_end && row_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_dst_q  <= '0;
      row_src_q  <= '0;
      dst_addr_o <= '0;
      src_addr_o <= '0;
      col_q      <= '0;
      row_q      <= '0;
    end else if (start_i) begin
      row_dst_q  <= dst0_i;
      row_src_q  <= src0_i;
      dst_addr_o <= dst0_i;
      src_addr_o <= src0_i;
      col_q      <= '0;
      row_q      <= '0;
    end else if (step_i) begin
      if (col_end) begin
        col_q <= '0;
        if (!row_end) begin
          row_q      <= row_q + DIM_W'(1);
          row_dst_q  <= nxt_row_dst;
          row_src_q  <= nxt_row_src;
          dst_addr_o <= nxt_row_dst;
          src_addr_o <= nxt_row_src;
        end
      end else begin
        col_q      <= col_q + DIM_W'(1);
        dst_addr_o <= back_i ? dst_addr_o - ADDR_W'(1) : dst_addr_o + ADDR_W'(1);
        src_addr_o <= back_i ? src_addr_o - ADDR_W'(1) : src_addr_o + ADDR_W'(1);
      end
    end
  end

  // R4: within a row both streams move together, so their distance is fixed
  assert_shared_direction_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !col_end) |=> ((dst_addr_o - src_addr_o) == $past(dst_addr_o - src_addr_o)));
  // R6: a started walk begins at the commanded start addresses
  assert_start_addr_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (dst_addr_o == $past(dst0_i)) && (src_addr_o == $past(src0_i)));
endmodule

// File: rtl/blit_copy_engine.sv
module blit_copy_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_data_i,
  output logic              cmd_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  eng_state_e        state_q;
  blit_cmd_t         cmd;
  logic              cmd_legal, last_word, collecting;
  logic              walk_start, walk_step, walk_last, empty_rect;
  logic [ADDR_W-1:0] dst_addr, src_addr;
  logic [DATA_W-1:0] src_q, rop_res;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE) || collecting;

  blit_cmd_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .in_valid_i   (cmd_valid_i),
    .in_data_i    (cmd_data_i),
    .in_ready_i   (cmd_ready_o),
    .last_word_o  (last_word),
    .collecting_o (collecting),
    .cmd_o        (cmd),
    .legal_o      (cmd_legal)
  );

  assign empty_rect = (cmd.width == '0) || (cmd.height == '0);
  assign walk_start = (state_q == ST_CHECK) && cmd_legal && !empty_rect;
  assign walk_step  = (state_q == ST_WRITE);

  blit_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (walk_start),
    .step_i     (walk_step),
    .back_i     (cmd.back),
    .dst0_i     (cmd.dst[ADDR_W-1:0]),
    .src0_i     (cmd.src[ADDR_W-1:0]),
    .dpitch_i   (cmd.dpitch),
    .spitch_i   (cmd.spitch),
    .width_i    (cmd.width),
    .height_i   (cmd.height),
    .dst_addr_o (dst_addr),
    .src_addr_o (src_addr),
    .last_o     (walk_last)
  );

  blit_rop #(.DATA_W(DATA_W)) u_rop (
    .rop_i (cmd.rop),
    .src_i (src_q),
    .dst_i (mem_rdata_i),
    .res_o (rop_res)
  );

  assign mem_addr_o  = (state_q == ST_RD_SRC) ? src_addr : dst_addr;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = rop_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      src_q   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE:   if (last_word) state_q <= ST_CHECK;
        ST_CHECK: begin
          if (!cmd_legal) begin
            err_o   <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (empty_rect) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_SRC;
          end
        end
        ST_RD_SRC: state_q <= ST_RD_DST;
        ST_RD_DST: begin
          src_q   <= mem_rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (walk_last) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_SRC;
          end
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: busy only drops together with the done pulse
  assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R11: the error flag holds until reset
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  // R1: a rejected command flags an error and writes nothing
  assert_reject_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && !cmd_legal) |=> (err_o && done_o && !mem_we_o));
  // R8: memory is written only while a command is in progress
  assert_write_in_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
endmodule

// File: tb/blit_copy_engine_tb_top.sv
module blit_copy_engine_tb_top;
  localparam int MEM_N = 1024;

  typedef struct packed {
    logic        back;
    logic [1:0]  depth;
    logic [7:0]  rop;
    logic [15:0] dp;
    logic [13:0] sp;
    logic [15:0] w;
    logic [15:0] h;
    logic [31:0] dst;
    logic [31:0] src;
    logic [15:0] exp_wr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 8'hCC, 16'd16,    14'd16,    16'd4, 16'd3, 32'd512, 32'd100, 16'd12},
    '{1'b1, 2'b01, 8'hCC, 16'd32,    14'd24,    16'd5, 16'd2, 32'd604, 32'd204, 16'd10},
    '{1'b0, 2'b10, 8'h66, 16'hFFF0,  14'h3FF8,  16'd3, 16'd4, 32'd800, 32'd300, 16'd12},
    '{1'b0, 2'b00, 8'h88, 16'd8,     14'd40,    16'd7, 16'd1, 32'd700, 32'd50,  16'd7},
    '{1'b1, 2'b01, 8'h11, 16'hFFD8,  14'h3FF0,  16'd2, 16'd3, 32'd950, 32'd450, 16'd6},
    '{1'b0, 2'b00, 8'hCC, 16'd8,     14'd8,     16'd6, 16'd2, 32'd400, 32'd403, 16'd12}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready, mem_we, busy, done, err;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem    [MEM_N];
  logic [7:0]  shadow [MEM_N];
  logic [7:0]  snap   [MEM_N];
  int n_chk = 0, n_fail = 0;
  int wr_cnt;
  bit ready_in_exec;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blit_copy_engine dut_i (
    .clk (clk), .rst (rst),
    .cmd_valid_i (cmd_valid), .cmd_data_i (cmd_data), .cmd_ready_o (cmd_ready),
    .mem_addr_o (mem_addr), .mem_we_o (mem_we), .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata), .busy_o (busy), .done_o (done), .err_o (err)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rop_m(input logic [7:0] r, input logic [7:0] s, input logic [7:0] d);
    logic [7:0] o;
    for (int b = 0; b < 8; b++) o[b] = r[int'(s[b]) * 2 + int'(d[b])];
    return o;
  endfunction

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== shadow[i]) m++;
    return m;
  endfunction

  task automatic model(input vec_t v);
    int rd = int'(v.dst), rs = int'(v.src);
    for (int r = 0; r < int'(v.h); r++) begin
      for (int c = 0; c < int'(v.w); c++) begin
        int d = v.back ? rd - c : rd + c;
        int s = v.back ? rs - c : rs + c;
        shadow[d] = rop_m(v.rop, shadow[s], shadow[d]);
      end
      rd += int'($signed(v.dp));
      rs += int'($signed(v.sp));
    end
  endtask

  function automatic logic [31:0] w1_of(input vec_t v);
    return {1'b0, v.back, 3'b000, 1'b1, v.depth, v.rop, v.dp};
  endfunction

  localparam logic [31:0] HDR = {3'd2, 7'h43, 17'd0, 5'd4};

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Sends six words, then waits for done; counts writes and ready-during-exec.
  task automatic run(input logic [31:0] a, b, c, d, e, f, input string req);
    logic [31:0] w [6];
    bit seen = 1'b0;
    w = '{a, b, c, d, e, f};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = w[i];
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R10", "busy after command", int'(busy), 1);
    wr_cnt = 0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      if (mem_we === 1'b1) begin
        wr_cnt++;
        if (cmd_ready === 1'b1) ready_in_exec = 1'b1;
      end
      if (done === 1'b1) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, req, "done seen", int'(seen), 1);
    chk(busy === 1'b0, "R10", "busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done single pulse", int'(done), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t v;
    ready_in_exec = 1'b0;
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = mem[i];
    end
    do_reset();
    // R12 reset state
    chk(cmd_ready === 1'b1, "R12", "ready", int'(cmd_ready), 1);
    chk(busy === 1'b0, "R12", "busy", int'(busy), 0);
    chk(done === 1'b0, "R12", "done", int'(done), 0);
    chk(err === 1'b0, "R12", "err", int'(err), 0);
    chk(mem_we === 1'b0, "R12", "we", int'(mem_we), 0);

    // Table: R4 backward rows, R5 signed pitches, R6 write count, R7 rops, R2 depths, R8 overlap
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      run(HDR, w1_of(v), {v.h, v.w}, v.dst, {18'd0, v.sp}, v.src, "R6");
      model(v);
      chk(wr_cnt == int'(v.exp_wr), "R6", $sformatf("write count vec %0d", k), wr_cnt, int'(v.exp_wr));
      chk(mismatches() == 0, "R5", $sformatf("R4/R7 memory image vec %0d", k), mismatches(), 0);
      chk(err === 1'b0, "R2", $sformatf("no error vec %0d", k), int'(err), 0);
    end

    // R8: same 32-byte line, shifted right by one, walked backward
    for (int i = 0; i < MEM_N; i++) snap[i] = mem[i];
    v = '{1'b1, 2'b00, 8'hCC, 16'd0, 14'd0, 16'd8, 16'd1, 32'd72, 32'd71, 16'd8};
    run(HDR, w1_of(v), {v.h, v.w}, v.dst, {18'd0, v.sp}, v.src, "R8");
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) if (mem[65 + i] !== snap[64 + i]) bad++;
      chk(bad == 0, "R8", "same-line overlap move", bad, 0);
    end
    model(v);

    // R9: zero width, then zero height
    run(HDR, w1_of(v), {16'd3, 16'd0}, 32'd10, 32'd0, 32'd20, "R9");
    chk(wr_cnt == 0 && err === 1'b0, "R9", "zero width writes", wr_cnt, 0);
    run(HDR, w1_of(v), {16'd0, 16'd5}, 32'd10, 32'd0, 32'd20, "R9");
    chk(wr_cnt == 0 && err === 1'b0, "R9", "zero height writes", wr_cnt, 0);
    chk(!ready_in_exec, "R10", "ready low during execution", int'(ready_in_exec), 0);

    // Rejections, each after a fresh reset
    begin
      logic [31:0] bad_w [6][6];
      string       tag [6];
      logic [31:0] good1;
      good1 = {1'b0, 1'b0, 3'b000, 1'b1, 2'b00, 8'hCC, 16'd4};
      bad_w[0] = '{{3'd2, 7'h42, 17'd0, 5'd4}, good1, {16'd1, 16'd2}, 32'd30, 32'd8, 32'd40}; tag[0] = "R1";
      bad_w[1] = '{{3'd2, 7'h43, 17'd0, 5'd5}, good1, {16'd1, 16'd2}, 32'd30, 32'd8, 32'd40}; tag[1] = "R1";
      bad_w[2] = '{HDR, good1 | 32'h0300_0000,      {16'd1, 16'd2}, 32'd30, 32'd8, 32'd40};   tag[2] = "R2";
      bad_w[3] = '{HDR, good1 & ~32'h0400_0000,     {16'd1, 16'd2}, 32'd30, 32'd8, 32'd40};   tag[3] = "R2";
      bad_w[4] = '{HDR, good1, {16'd1, 16'd2}, 32'd30, 32'd12, 32'd40};                       tag[4] = "R3";
      bad_w[5] = '{HDR, good1, {16'd1, 16'd2}, 32'd30, 32'h0000_4008, 32'd40};                tag[5] = "R3";
      for (int k = 0; k < 6; k++) begin
        do_reset();
        run(bad_w[k][0], bad_w[k][1], bad_w[k][2], bad_w[k][3], bad_w[k][4], bad_w[k][5], tag[k]);
        chk(err === 1'b1, tag[k], $sformatf("reject case %0d err", k), int'(err), 1);
        chk(wr_cnt == 0, tag[k], $sformatf("reject case %0d writes", k), wr_cnt, 0);
      end
      chk(mismatches() == 0, "R1", "memory untouched by rejects", mismatches(), 0);

      // R11: sticky error, legal command still executes
      v = '{1'b0, 2'b00, 8'hCC, 16'd4, 14'd8, 16'd2, 16'd2, 32'd20, 32'd2, 16'd4};
      run(HDR, w1_of(v), {v.h, v.w}, v.dst, {18'd0, v.sp}, v.src, "R11");
      model(v);
      chk(err === 1'b1, "R11", "err stays set", int'(err), 1);
      chk(wr_cnt == 4 && mismatches() == 0, "R11", "legal command after error", wr_cnt, 4);

      // R11: illegal and empty at once -> error wins
      do_reset();
      run({3'd2, 7'h41, 17'd0, 5'd4}, good1, {16'd3, 16'd0}, 32'd30, 32'd8, 32'd40, "R11");
      chk(err === 1'b1 && wr_cnt == 0, "R11", "illegal empty command", int'(err), 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule